// File: doc/BRIEF.md
# System Register I/O Page Decoder

This block decodes the CPU's system control registers that sit in the top 8 KB I/O page of a 16-bit minicomputer. A simple synchronous bus presents a 16-bit address, a byte/word select, read and write strobes, 16-bit write data and a peek qualifier for debug reads. The block holds the status word image, the stack limit, the CPU error, the microprogram break and the console LED registers. It answers the constant maintenance, identity and memory-size registers and two reserved windows that read as zero. When an access cannot be performed, it raises a one-cycle trap request toward vector 004.

Each register has its own byte-lane write rules and forced bits. A peek read never has a side effect and never traps. The CPU core reaches the block through a small register port: it can load the status word and it can set error bits. Read data is registered and appears in the cycle after the read strobe.

Top module: `sysio_page`

## Requirements
- R1: After synchronous reset the status word, error, break and LED registers are 0x0000, the stack limit is 0x00FF, `bus_rdata` is 0x0000 and `trap_req` is low.
- R2: A word access (`bus_byte`=0) to an odd address is not performed. In the next cycle it raises `trap_req` for one cycle, with `trap_addr` equal to that address, and a read returns 0xFFFF. A byte access to an odd address is legal and selects the high byte, which is returned in bits 7:0.
- R3: A non-peek read or write of an address that no register decodes traps as in R2, and the read returns 0xFFFF. A peek read of such an address, or a peek word read of an odd address, returns 0xFFFF without a trap. A peek read of a decoded register returns its value.
- R4: The status word sits at 0177776 (octal). Every bus write to it forces bit 4 to 0, and a byte write replaces only the addressed half. A core load (`core_psw_ld`) writes `core_psw_d` unchanged, but a bus write in the same cycle takes priority.
- R5: The stack limit sits at 0177774. A word write stores bits 15:8 and clears bits 7:0. A byte write to either half merges and then forces bits 7:0 to 0xFF.
- R6: The error register sits at 0177766. Any bus write clears it, whatever the data. Bits of `core_err_set` are ORed in each cycle, and in a clearing cycle the register takes exactly `core_err_set`. A byte read at 0177766 returns the low 8 bits.
- R7: The break register sits at 0177770. A word write stores only bits 7:0 (15:8 become 0), and a byte write replaces the addressed half.
- R8: The maintenance register at 0177730 reads 0x0001, and the identity register at 0177764 reads 0x1234 (octal 011064). Writes to either are ignored and do not trap.
- R9: The size registers at 0177760 (low) and 0177762 (high) read the 32-bit value MEM_BYTES/64-1 split into halves (0xFFFF and 0x0001 by default). Writes are ignored and do not trap.
- R10: Addresses 0177740-0177753 and 0170200-0170377 read 0x0000. Writes there have no effect, and no access in these windows traps.
- R11: A write to 0177570 updates `led_q` with byte-lane merging. A read of 0177570 returns `sw_in`.
- R12: `bus_rdata` changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_peek | input | 1 | Side-effect-free debug read qualifier |
| bus_wdata | input | 16 | Write data (bits 7:0 for byte writes) |
| bus_rdata | output | 16 | Registered read data |
| trap_req | output | 1 | One-cycle bus-error trap request |
| trap_addr | output | 16 | Address of the faulting access |
| sw_in | input | 16 | Console switch inputs |
| led_q | output | 16 | Console LED register |
| core_psw_ld | input | 1 | Core loads the status word |
| core_psw_d | input | 16 | Status word value from the core |
| core_err_set | input | 16 | Error bits raised by the core |
| psw_q | output | 16 | Current status word |
| stklim_q | output | 16 | Current stack limit |

## Verification
Two pairs of functions can meet in one cycle. A bus write that clears the error register can coincide with the core raising new error bits. A bus write of the status word can coincide with a core load of it. The bench drives both sources in the same cycle. It then judges the result by reading the error register back over the bus, where only the newly raised bits must survive, and by observing `psw_q`, which must show the bus value with bit 4 cleared.

// File: rtl/sysio_pkg.sv
package sysio_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  // Register addresses (word-aligned)
  localparam logic [WORD_W-1:0] A_PSW   = 16'o177776;
  localparam logic [WORD_W-1:0] A_STK   = 16'o177774;
  localparam logic [WORD_W-1:0] A_BRK   = 16'o177770;
  localparam logic [WORD_W-1:0] A_ERR   = 16'o177766;
  localparam logic [WORD_W-1:0] A_SID   = 16'o177764;
  localparam logic [WORD_W-1:0] A_SZHI  = 16'o177762;
  localparam logic [WORD_W-1:0] A_SZLO  = 16'o177760;
  localparam logic [WORD_W-1:0] A_MNT   = 16'o177730;
  localparam logic [WORD_W-1:0] A_CON   = 16'o177570;
  localparam logic [WORD_W-1:0] CACHE_LO = 16'o177740;
  localparam logic [WORD_W-1:0] CACHE_HI = 16'o177753;
  localparam logic [WORD_W-1:0] MAP_LO   = 16'o170200;
  localparam logic [WORD_W-1:0] MAP_HI   = 16'o170377;

  localparam logic [WORD_W-1:0] SID_VAL   = 16'o011064;
  localparam logic [WORD_W-1:0] MNT_VAL   = 16'h0001;
  localparam logic [WORD_W-1:0] TRACE_BIT = 16'h0010;
  localparam logic [WORD_W-1:0] ALL_ONES  = '1;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_PSW, SEL_STK, SEL_BRK, SEL_ERR, SEL_MNT,
    SEL_SID, SEL_SZLO, SEL_SZHI, SEL_CON, SEL_ZERO
  } sel_e;

  // Replace the addressed byte lane, or the whole word
  function automatic logic [WORD_W-1:0] lane_merge(
      input logic [WORD_W-1:0] old_v, input logic [WORD_W-1:0] new_v,
      input logic byte_acc, input logic hi);
    if (!byte_acc)
      return new_v;
    else if (hi)
      return {new_v[BYTE_W-1:0], old_v[BYTE_W-1:0]};
    else
      return {old_v[WORD_W-1:BYTE_W], new_v[BYTE_W-1:0]};
  endfunction
endpackage

// File: rtl/sysio_decode.sv
module sysio_decode
  import sysio_pkg::*;
(
  input  logic [WORD_W-1:0] addr,
  input  logic              byte_acc,
  output sel_e              sel,
  output logic              odd_word
);
  logic [WORD_W-1:0] wa;

  always_comb begin
    wa       = {addr[WORD_W-1:1], 1'b0};
    odd_word = addr[0] & ~byte_acc;
    sel      = SEL_NONE;
    case (wa)
      A_PSW:  sel = SEL_PSW;
      A_STK:  sel = SEL_STK;
      A_BRK:  sel = SEL_BRK;
      A_ERR:  sel = SEL_ERR;
      A_SID:  sel = SEL_SID;
      A_SZLO: sel = SEL_SZLO;
      A_SZHI: sel = SEL_SZHI;
      A_MNT:  sel = SEL_MNT;
      A_CON:  sel = SEL_CON;
      default: begin
        if ((wa >= CACHE_LO && wa <= CACHE_HI) || (wa >= MAP_LO && wa <= MAP_HI))
          sel = SEL_ZERO;
      end
    endcase
  end
endmodule

// File: rtl/sysio_regs.sv
module sysio_regs
  import sysio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  sel_e              sel,
  input  logic              byte_acc,
  input  logic              hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic              core_psw_ld,
  input  logic [WORD_W-1:0] core_psw_d,
  input  logic [WORD_W-1:0] core_err_set,
  output logic [WORD_W-1:0] psw_q,
  output logic [WORD_W-1:0] stk_q,
  output logic [WORD_W-1:0] brk_q,
  output logic [WORD_W-1:0] err_q,
  output logic [WORD_W-1:0] led_q
);
  localparam logic [WORD_W-1:0] LOW_ONES = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};

  logic psw_wr, stk_wr, brk_wr, err_wr, con_wr;
  assign psw_wr = we && (sel == SEL_PSW);
  assign stk_wr = we && (sel == SEL_STK);
  assign brk_wr = we && (sel == SEL_BRK);
  assign err_wr = we && (sel == SEL_ERR);
  assign con_wr = we && (sel == SEL_CON);

  always_ff @(posedge clk) begin
    if (rst) begin
      psw_q <= '0;
      stk_q <= LOW_ONES;
      brk_q <= '0;
      err_q <= '0;
      led_q <= '0;
    end else begin
      // bus write outranks a core load
      if (psw_wr)
        psw_q <= lane_merge(psw_q, wdata, byte_acc, hi) & ~TRACE_BIT;
      else if (core_psw_ld)
        psw_q <= core_psw_d;

      if (stk_wr) begin
        if (byte_acc) stk_q <= lane_merge(stk_q, wdata, 1'b1, hi) | LOW_ONES;
        else          stk_q <= wdata & ~LOW_ONES;
      end

      if (brk_wr) begin
        if (byte_acc) brk_q <= lane_merge(brk_q, wdata, 1'b1, hi);
        else          brk_q <= wdata & LOW_ONES;
      end

      // newly raised error bits survive a clearing write
      if (err_wr) err_q <= core_err_set;
      else        err_q <= err_q | core_err_set;

      if (con_wr) led_q <= lane_merge(led_q, wdata, byte_acc, hi);
    end
  end

  a_r4_trace_cleared: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(psw_wr)) |-> !psw_q[4]);
  a_r5_stk_low_ones: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(stk_wr && byte_acc)) |-> (stk_q[BYTE_W-1:0] == '1));
  a_r6_err_cleared: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(err_wr)) |-> (err_q == $past(core_err_set)));
  a_r7_brk_high_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(brk_wr && !byte_acc)) |-> (brk_q[WORD_W-1:BYTE_W] == '0));
endmodule

// File: rtl/sysio_rdmux.sv
module sysio_rdmux
  import sysio_pkg::*;
(
  input  sel_e              sel,
  input  logic              byte_acc,
  input  logic              hi,
  input  logic [WORD_W-1:0] psw,
  input  logic [WORD_W-1:0] stk,
  input  logic [WORD_W-1:0] brk,
  input  logic [WORD_W-1:0] err,
  input  logic [WORD_W-1:0] size_lo,
  input  logic [WORD_W-1:0] size_hi,
  input  logic [WORD_W-1:0] sw,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] raw;

  always_comb begin
    case (sel)
      SEL_PSW:  raw = psw;
      SEL_STK:  raw = stk;
      SEL_BRK:  raw = brk;
      SEL_ERR:  raw = err;
      SEL_MNT:  raw = MNT_VAL;
      SEL_SID:  raw = SID_VAL;
      SEL_SZLO: raw = size_lo;
      SEL_SZHI: raw = size_hi;
      SEL_CON:  raw = sw;
      SEL_ZERO: raw = '0;
      default:  raw = ALL_ONES;
    endcase
    rd_word = raw;
    if (byte_acc && sel != SEL_NONE)
      rd_word = hi ? {{BYTE_W{1'b0}}, raw[WORD_W-1:BYTE_W]}
                   : {{BYTE_W{1'b0}}, raw[BYTE_W-1:0]};
  end
endmodule

// File: rtl/sysio_page.sv
module sysio_page
  import sysio_pkg::*;
#(
  parameter longint unsigned MEM_BYTES = 64'd8388608
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] bus_addr,
  input  logic        bus_byte,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic        bus_peek,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        trap_req,
  output logic [15:0] trap_addr,
  input  logic [15:0] sw_in,
  output logic [15:0] led_q,
  input  logic        core_psw_ld,
  input  logic [15:0] core_psw_d,
  input  logic [15:0] core_err_set,
  output logic [15:0] psw_q,
  output logic [15:0] stklim_q
);
  localparam logic [2*WORD_W-1:0] SIZE_VAL = (2*WORD_W)'(MEM_BYTES / 64 - 1);

  sel_e              sel;
  logic              odd_word;
  logic              peek_rd, access, fault, we;
  logic [WORD_W-1:0] brk_q, err_q, rd_word;

  sysio_decode u_dec (
    .addr(bus_addr), .byte_acc(bus_byte), .sel(sel), .odd_word(odd_word)
  );

  assign peek_rd = bus_rd && bus_peek && !bus_wr;
  assign access  = bus_rd || bus_wr;
  assign fault   = access && (odd_word || sel == SEL_NONE) && !peek_rd;
  assign we      = bus_wr && !odd_word;

  sysio_regs u_regs (
    .clk(clk), .rst(rst), .we(we), .sel(sel), .byte_acc(bus_byte),
    .hi(bus_addr[0]), .wdata(bus_wdata), .core_psw_ld(core_psw_ld),
    .core_psw_d(core_psw_d), .core_err_set(core_err_set),
    .psw_q(psw_q), .stk_q(stklim_q), .brk_q(brk_q), .err_q(err_q), .led_q(led_q)
  );

  sysio_rdmux u_mux (
    .sel(sel), .byte_acc(bus_byte), .hi(bus_addr[0]),
    .psw(psw_q), .stk(stklim_q), .brk(brk_q), .err(err_q),
    .size_lo(SIZE_VAL[WORD_W-1:0]), .size_hi(SIZE_VAL[2*WORD_W-1:WORD_W]),
    .sw(sw_in), .rd_word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      trap_req  <= 1'b0;
      trap_addr <= '0;
    end else begin
      if (bus_rd) bus_rdata <= odd_word ? ALL_ONES : rd_word;
      trap_req <= fault;
      if (fault) trap_addr <= bus_addr;
    end
  end

  a_r2_trap_needs_access: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(access));
  a_r2_odd_word_traps: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(access && odd_word && !peek_rd))
      |-> (trap_req && trap_addr == $past(bus_addr)));
  a_r3_peek_silent: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(peek_rd)) |-> !trap_req);
  a_r10_window_silent: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(access && sel == SEL_ZERO && !odd_word)) |-> !trap_req);
  a_r12_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!bus_rd)) |-> $stable(bus_rdata));
endmodule

// File: tb/sysio_page_test.sv
`timescale 1ns/1ps
module sysio_page_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic        bus_byte = 0, bus_rd = 0, bus_wr = 0, bus_peek = 0;
  logic [15:0] bus_rdata, trap_addr, led_q, psw_q, stklim_q;
  logic        trap_req;
  logic [15:0] sw_in = 16'hA5C3;
  logic        core_psw_ld = 0;
  logic [15:0] core_psw_d = '0, core_err_set = '0;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sysio_page uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_byte(bus_byte),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_peek(bus_peek), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .trap_req(trap_req), .trap_addr(trap_addr),
    .sw_in(sw_in), .led_q(led_q), .core_psw_ld(core_psw_ld),
    .core_psw_d(core_psw_d), .core_err_set(core_err_set),
    .psw_q(psw_q), .stklim_q(stklim_q)
  );

  // {req[3:0], wr, byte, peek, trap, addr[15:0], data[15:0]}; data is expected value for reads
  localparam int NV = 50;
  localparam logic [39:0] VEC [NV] = '{
    {4'd1,  4'b0000, 16'o177776, 16'h0000},  // R1 psw reset
    {4'd1,  4'b0000, 16'o177774, 16'h00FF},  // R1 stack limit reset
    {4'd4,  4'b1000, 16'o177776, 16'hFFFF},  // R4
    {4'd4,  4'b0000, 16'o177776, 16'hFFEF},
    {4'd4,  4'b1100, 16'o177776, 16'h0000},
    {4'd4,  4'b0000, 16'o177776, 16'hFF00},
    {4'd4,  4'b1100, 16'o177777, 16'h0012},
    {4'd4,  4'b0000, 16'o177776, 16'h1200},
    {4'd2,  4'b0100, 16'o177777, 16'h0012},  // R2 odd byte read
    {4'd5,  4'b1000, 16'o177774, 16'hABCD},  // R5
    {4'd5,  4'b0000, 16'o177774, 16'hAB00},
    {4'd5,  4'b1100, 16'o177775, 16'h005A},
    {4'd5,  4'b0000, 16'o177774, 16'h5AFF},
    {4'd5,  4'b1100, 16'o177774, 16'h0000},
    {4'd5,  4'b0000, 16'o177774, 16'h5AFF},
    {4'd7,  4'b1000, 16'o177770, 16'hBEEF},  // R7
    {4'd7,  4'b0000, 16'o177770, 16'h00EF},
    {4'd7,  4'b1100, 16'o177771, 16'h0077},
    {4'd7,  4'b0000, 16'o177770, 16'h77EF},
    {4'd7,  4'b0100, 16'o177771, 16'h0077},
    {4'd8,  4'b0000, 16'o177730, 16'h0001},  // R8
    {4'd8,  4'b1000, 16'o177730, 16'h0000},
    {4'd8,  4'b0000, 16'o177730, 16'h0001},
    {4'd8,  4'b0000, 16'o177764, 16'h1234},
    {4'd8,  4'b1000, 16'o177764, 16'hFFFF},
    {4'd8,  4'b0000, 16'o177764, 16'h1234},
    {4'd9,  4'b0000, 16'o177760, 16'hFFFF},  // R9
    {4'd9,  4'b0000, 16'o177762, 16'h0001},
    {4'd9,  4'b1000, 16'o177760, 16'h0000},
    {4'd9,  4'b1000, 16'o177762, 16'h0000},
    {4'd9,  4'b0000, 16'o177760, 16'hFFFF},
    {4'd9,  4'b0000, 16'o177762, 16'h0001},
    {4'd10, 4'b0000, 16'o177740, 16'h0000},  // R10
    {4'd10, 4'b0000, 16'o177752, 16'h0000},
    {4'd10, 4'b1000, 16'o177746, 16'hFFFF},
    {4'd10, 4'b0000, 16'o177746, 16'h0000},
    {4'd10, 4'b0000, 16'o170200, 16'h0000},
    {4'd10, 4'b0100, 16'o170377, 16'h0000},
    {4'd10, 4'b1000, 16'o170300, 16'h1234},
    {4'd11, 4'b1000, 16'o177570, 16'h1357},  // R11
    {4'd11, 4'b0000, 16'o177570, 16'hA5C3},
    {4'd2,  4'b0001, 16'o177777, 16'hFFFF},  // R2 odd word read
    {4'd2,  4'b1001, 16'o177775, 16'h0000},  // R2 odd word write
    {4'd2,  4'b0000, 16'o177774, 16'h5AFF},
    {4'd3,  4'b0001, 16'o160000, 16'hFFFF},  // R3
    {4'd3,  4'b0010, 16'o160000, 16'hFFFF},
    {4'd3,  4'b0010, 16'o177777, 16'hFFFF},
    {4'd3,  4'b1001, 16'o160002, 16'h1111},
    {4'd3,  4'b0010, 16'o177776, 16'h1200},
    {4'd3,  4'b0101, 16'o160001, 16'hFFFF}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge (after one rising edge)
  task automatic acc(input logic w, input logic b, input logic p,
                     input logic [15:0] a, input logic [15:0] d);
    bus_wr = w; bus_rd = !w; bus_byte = b; bus_peek = p;
    bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bus_byte = 0; bus_peek = 0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state at the ports
    chk(trap_req == 0, "R1", "trap_req", {15'd0, trap_req}, 16'h0);
    chk(bus_rdata == 16'h0, "R1", "rdata", bus_rdata, 16'h0);
    chk(stklim_q == 16'h00FF, "R1", "stklim", stklim_q, 16'h00FF);
    chk(led_q == 16'h0, "R1", "led", led_q, 16'h0);
    chk(psw_q == 16'h0, "R1", "psw", psw_q, 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d vec%0d", v[39:36], i);
      acc(v[35], v[34], v[33], v[31:16], v[15:0]);
      if (!v[35]) chk(bus_rdata == v[15:0], rq, "rdata", bus_rdata, v[15:0]);
      chk(trap_req == v[32], rq, "trap", {15'd0, trap_req}, {15'd0, v[32]});
      if (v[32]) chk(trap_addr == v[31:16], rq, "trap_addr", trap_addr, v[31:16]);
    end

    // R11 LED register and byte merge
    chk(led_q == 16'h1357, "R11", "led", led_q, 16'h1357);
    acc(1, 1, 0, 16'o177571, 16'h0024);
    chk(led_q == 16'h2457, "R11", "led byte", led_q, 16'h2457);

    // R12 rdata holds with no read strobe
    acc(0, 0, 0, 16'o177764, 16'h0);
    acc(1, 0, 0, 16'o177770, 16'h0000);
    @(negedge clk);
    chk(bus_rdata == 16'h1234, "R12", "rdata hold", bus_rdata, 16'h1234);

    // R6 error register
    core_err_set = 16'h0184;
    @(negedge clk);
    core_err_set = 16'h0;
    acc(0, 0, 0, 16'o177766, 16'h0);
    chk(bus_rdata == 16'h0184, "R6", "err set", bus_rdata, 16'h0184);
    acc(0, 1, 0, 16'o177766, 16'h0);
    chk(bus_rdata == 16'h0084, "R6", "err byte", bus_rdata, 16'h0084);
    acc(1, 1, 0, 16'o177767, 16'h00FF);
    acc(0, 0, 0, 16'o177766, 16'h0);
    chk(bus_rdata == 16'h0000, "R6", "err cleared", bus_rdata, 16'h0000);
    core_err_set = 16'h0005;
    @(negedge clk);
    core_err_set = 16'h0030;   // same cycle as the clearing write
    acc(1, 0, 0, 16'o177766, 16'hFFFF);
    core_err_set = 16'h0;
    acc(0, 0, 0, 16'o177766, 16'h0);
    chk(bus_rdata == 16'h0030, "R6", "set vs clear", bus_rdata, 16'h0030);

    // R4 core load and priority
    core_psw_ld = 1; core_psw_d = 16'h0010;
    @(negedge clk);
    core_psw_ld = 0;
    chk(psw_q == 16'h0010, "R4", "core load", psw_q, 16'h0010);
    core_psw_ld = 1; core_psw_d = 16'h00F0;
    acc(1, 0, 0, 16'o177776, 16'h0011);
    core_psw_ld = 0;
    chk(psw_q == 16'h0001, "R4", "bus over core", psw_q, 16'h0001);

    // R1 reset mid-run
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(stklim_q == 16'h00FF, "R1", "stk re-reset", stklim_q, 16'h00FF);
    chk(led_q == 16'h0 && psw_q == 16'h0, "R1", "led|psw re-reset", led_q | psw_q, 16'h0);
    acc(0, 0, 0, 16'o177766, 16'h0);
    chk(bus_rdata == 16'h0, "R1", "err re-reset", bus_rdata, 16'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule